// File: doc/BRIEF.md
# Circulant GF(2^8) Byte Mixer

This unit performs the linear diffusion step of a 512-bit substitution-permutation hash round, one eight-byte group of the 8x8 byte state per cycle. Each of the eight output bytes is an XOR of the eight input bytes. Before the XOR, every input byte is multiplied in GF(2^8) by a constant taken from a fixed coefficient vector. The vector is rotated by one position for each successive output byte, so the whole mapping is a circulant 8x8 matrix.

A full state is mixed by streaming its eight groups through the unit, or by instantiating the unit eight times side by side. Byte substitution, the byte rotation step and the round-key XOR sit outside this block. The result can be presented through one output register stage or passed straight through, and the valid flag follows the same path as the data.

Top module: `circ_byte_mixer`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is 0 after that edge, even if `in_valid` is high in the same cycle.
- R2: Byte k of `in_bytes` is bits [8k+7:8k]. Byte 0 of the output is the XOR of input bytes 0..7, each multiplied by the coefficients 1, 9, 2, 5, 8, 1, 4, 1 respectively.
- R3: Output byte j multiplies input byte k by coefficient entry (k-j) mod 8. As a consequence, rotating the input up by one byte position rotates the output up by one byte position.
- R4: Products are reduced modulo x^8+x^4+x^3+x^2+1. For example, 2·0x80 = 0x1D.
- R5: With OUT_REG=1, the output bytes and `out_valid` appear one clock after the input is sampled. `out_valid` equals the value `in_valid` had one cycle earlier.
- R6: With OUT_REG=1, a cycle with `in_valid` low leaves `out_bytes` unchanged, whatever value `in_bytes` carries.
- R7: The coefficients XOR to 3. So an input whose eight bytes are all equal to x yields eight output bytes all equal to 3·x.
- R8: The mapping is linear. The mix of (a XOR b) equals the mix of a XOR the mix of b, and an all-zero group gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input group is valid this cycle |
| in_bytes | input | 64 | Eight input bytes, byte k at [8k+7:8k] |
| out_valid | output | 1 | Output group is valid |
| out_bytes | output | 64 | Eight mixed bytes, byte j at [8j+7:8j] |

## Verification
The key overlap is a result being presented while the next group is captured in the same edge. Groups are pushed back to back, and each is compared against a bench reference computed by shift-and-add field multiplication. A second overlap is reset arriving in the same cycle as a valid input; the bench requires that no valid output appears. Idle cycles carry random garbage on `in_bytes`, and the bench requires the previous result to stay on the port unchanged.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int unsigned LANES_DEF = 8;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned COEF_W    = 4;
  localparam logic [7:0]  POLY_LOW_DEF = 8'h1D;

  // circulant coefficient vector, entry idx (mod 8)
  function automatic logic [COEF_W-1:0] coef_at(input int unsigned idx);
    case (idx % 8)
      0: coef_at = 4'd1;
      1: coef_at = 4'd9;
      2: coef_at = 4'd2;
      3: coef_at = 4'd5;
      4: coef_at = 4'd8;
      5: coef_at = 4'd1;
      6: coef_at = 4'd4;
      default: coef_at = 4'd1;
    endcase
  endfunction

  function automatic logic [7:0] dbl(input logic [7:0] v);
    dbl = {v[6:0], 1'b0} ^ (v[7] ? POLY_LOW_DEF : 8'h00);
  endfunction
endpackage

// File: rtl/cbm_const_mul.sv
module cbm_const_mul #(
  parameter int unsigned CW       = 4,
  parameter logic [7:0]  POLY_LOW = 8'h1D,
  parameter logic [CW-1:0] COEF   = '0
) (
  input  logic [7:0] a,
  output logic [7:0] y
);
  // pw[i] = a * 2^i, built by a doubling chain
  logic [CW-1:0][7:0] pw;
  assign pw[0] = a;
  for (genvar i = 1; i < CW; i++) begin : g_dbl
    assign pw[i] = {pw[i-1][6:0], 1'b0} ^ ({8{pw[i-1][7]}} & POLY_LOW);
  end

  always_comb begin
    y = '0;
    for (int i = 0; i < CW; i++)
      if (COEF[i]) y = y ^ pw[i];
  end
endmodule

// File: rtl/cbm_lane.sv
module cbm_lane
  import cbm_pkg::*;
#(
  parameter int unsigned LANES    = 8,
  parameter logic [7:0]  POLY_LOW = 8'h1D,
  parameter int unsigned ROT      = 0
) (
  input  logic [LANES*BYTE_W-1:0] grp,
  output logic [BYTE_W-1:0]       y
);
  logic [LANES-1:0][BYTE_W-1:0] prod;

  for (genvar k = 0; k < LANES; k++) begin : g_term
    cbm_const_mul #(
      .CW(COEF_W),
      .POLY_LOW(POLY_LOW),
      .COEF(coef_at((k + LANES - ROT) % LANES))
    ) i_mul (
      .a(grp[k*BYTE_W +: BYTE_W]),
      .y(prod[k])
    );
  end

  always_comb begin
    y = '0;
    for (int k = 0; k < LANES; k++) y = y ^ prod[k];
  end
endmodule

// File: rtl/circ_byte_mixer.sv
module circ_byte_mixer
  import cbm_pkg::*;
#(
  parameter int unsigned LANES    = LANES_DEF,
  parameter logic [7:0]  POLY_LOW = POLY_LOW_DEF,
  parameter bit          OUT_REG  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANES*BYTE_W-1:0] in_bytes,
  output logic                    out_valid,
  output logic [LANES*BYTE_W-1:0] out_bytes
);
  localparam int unsigned DW = LANES * BYTE_W;

  logic [DW-1:0] mixed;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    cbm_lane #(.LANES(LANES), .POLY_LOW(POLY_LOW), .ROT(j)) i_lane (
      .grp(in_bytes),
      .y(mixed[j*BYTE_W +: BYTE_W])
    );
  end

  // R7: uniform input must give 3*x in every lane
  always_comb begin
    if (in_bytes == {LANES{in_bytes[BYTE_W-1:0]}} && LANES == 8 && POLY_LOW == 8'h1D)
      a_r7_uniform_triple: assert (mixed ==
        {LANES{dbl(in_bytes[BYTE_W-1:0]) ^ in_bytes[BYTE_W-1:0]}});
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        out_bytes <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) out_bytes <= mixed;
      end
    end

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    a_r5_idle_follows: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_bytes));
    a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> !out_valid);
  end else begin : g_comb
    assign out_valid = in_valid & ~rst;
    assign out_bytes = mixed;
  end
endmodule

// File: tb/test_circ_byte_mixer.sv
module test_circ_byte_mixer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_bytes;
  logic        out_valid;
  logic [63:0] out_bytes;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_byte_mixer i_circ_byte_mixer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_bytes(out_bytes)
  );

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = a[7] ? ((a << 1) ^ 8'h1D) : (a << 1);
    end
    return p;
  endfunction

  function automatic logic [63:0] ref_mix(input logic [63:0] a);
    int cv [8] = '{1, 9, 2, 5, 8, 1, 4, 1};
    logic [63:0] r = 0;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++)
        r[j*8 +: 8] ^= fmul(a[k*8 +: 8], 8'(cv[(k - j + 8) % 8]));
    return r;
  endfunction

  function automatic logic [63:0] rot_up(input logic [63:0] x);
    return {x[55:0], x[63:56]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // push one group, return the observed result one clock later
  task automatic push(input logic [63:0] d, output logic [63:0] res, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_bytes = d;
    @(posedge clk); #1;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    res = out_bytes;
    check(req, out_bytes, ref_mix(d));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] r, ra, rb, rab, a, b, held;
    void'($urandom(32'd4711));
    rst = 1'b1; in_valid = 1'b0; in_bytes = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {63'd0, out_valid}, 64'd0);
    @(negedge clk); rst = 1'b0;

    // R2: unit vector in each input position
    for (int k = 0; k < 8; k++) begin
      push(64'd1 << (8*k), r, "R2 unit");
    end
    push(64'h0000_0000_0000_0001, r, "R2 byte0");
    check("R2 coef column", r, 64'h0104_0108_0502_0901 & 64'hFFFF_FFFF_FFFF_FFFF
      ^ 64'h0104_0108_0502_0901 ^ {8'd9, 8'd2, 8'd5, 8'd8, 8'd1, 8'd4, 8'd1, 8'd1});

    // R4: reduction polynomial
    push(64'h0000_0000_0080_0000, r, "R4 reduce");
    check("R4 byte0", {56'd0, r[7:0]}, 64'h1D);

    // R7: uniform input
    push({8{8'h80}}, r, "R7 uniform");
    check("R7 triple", r, {8{8'h9D}});

    // R8: zero and linearity
    push(64'd0, r, "R8 zero");
    for (int t = 0; t < 20; t++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      push(a, ra, "R8 a");
      push(b, rb, "R8 b");
      push(a ^ b, rab, "R8 ab");
      check("R8 linear", rab, ra ^ rb);
    end

    // R3: rotation equivariance, back to back groups
    for (int t = 0; t < 20; t++) begin
      a = {$urandom, $urandom};
      push(a, ra, "R3 base");
      push(rot_up(a), rb, "R3 rot");
      check("R3 circulant", rb, rot_up(ra));
    end

    // R5/R6: idle cycles with garbage on the bus
    push({$urandom, $urandom}, held, "R5 load");
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_bytes = {$urandom, $urandom};
      @(posedge clk); #1;
      check("R5 idle valid", {63'd0, out_valid}, 64'd0);
      check("R6 hold", out_bytes, held);
    end

    // random stream
    for (int t = 0; t < 200; t++) push({$urandom, $urandom}, r, "R2 random");

    // R1: reset coinciding with valid input
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_bytes = {$urandom, $urandom};
    @(posedge clk); #1;
    check("R1 reset with valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule